// File: doc/BRIEF.md
# Parallel Priority Interrupt Controller

This block collects a set of interrupt request lines from peripherals and decides which one the processor services next. Each line passes through its own mask bit; the surviving requests feed a priority encoder in which the lowest-numbered line always wins. While any unmasked line is active, a sticky status flag is set. A separate enable flag, written only by software, gates that status flag onto the processor's interrupt output.

When the processor acknowledges, the controller captures the winning line's vector address and holds it on the vector output for the length of the acknowledge. On that edge it also clears the enable flag, so no second interrupt can be taken until software sets the flag again.

Software reaches the block through a small write port. It can load the mask, set or clear the enable flag, and clear the status flag. A service routine uses the mask to hold off lower-priority lines while it runs.

Top module: `prio_intc`

## Requirements
- R1: Among unmasked active requests, the lowest index wins; line 0 has the highest priority.
- R2: A request whose mask bit is 0 is ignored: it neither sets the status flag nor supplies a vector.
- R3: The status flag is set on any clock edge at which an unmasked request is active. It stays set until a write to register address 2 clears it. Such a clear has no effect while an unmasked request is still active.
- R4: The enable flag changes only on a write to register address 1, which loads it from wdata bit 0, or on an acknowledge. A write to address 3 changes nothing.
- R5: The interrupt output is high exactly when both the enable flag and the status flag are set.
- R6: On a rising edge of the acknowledge input, the enable flag is cleared one cycle later. This overrides a write to the enable flag in the same cycle.
- R7: On the acknowledge rising edge, the vector becomes VEC_BASE + 4 × (winning index), which is 0x0100 + 4·i at the default parameters. It is visible from the next cycle and holds while acknowledge stays high, whatever the requests do in the meantime.
- R8: The vector output is 0 whenever acknowledge is low. It is also 0 during an acknowledge that began with no unmasked request active.
- R9: A write to register address 0 loads the mask from wdata; a mask bit of 1 enables that line.
- R10: After synchronous reset, the mask, the enable flag, the status flag, the interrupt output and the vector are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NUM_SRC | Request lines, bit 0 highest priority |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 mask, 1 enable, 2 status clear, 3 unused |
| reg_wdata | input | NUM_SRC | Write data |
| inta_i | input | 1 | Interrupt acknowledge from the processor |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_o | output | VEC_W | Vector address, valid during acknowledge |
| ien_o | output | 1 | Enable flag |
| ist_o | output | 1 | Status flag |
| mask_o | output | NUM_SRC | Mask register |

## Verification
The flags and the mask are brought out at the ports. A corrupted enable flag, status flag or mask therefore shows up one cycle after the write or request that should have set it, and it shows on irq_o in the same cycle. A wrong encoder decision or a bad capture at acknowledge appears as a wrong vec_o in the first cycle of the acknowledge. A failure to hold the captured vector appears once the requests change during the acknowledge, and a failure to return to zero appears in the cycle after acknowledge falls.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic [1:0] {
    RA_MASK    = 2'd0,
    RA_ENABLE  = 2'd1,
    RA_STS_CLR = 2'd2,
    RA_SPARE   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/intc_mask_gate.sv
module intc_mask_gate #(
  parameter int NUM_SRC = 8
) (
  input  logic [NUM_SRC-1:0] req,
  input  logic [NUM_SRC-1:0] mask,
  output logic [NUM_SRC-1:0] gated,
  output logic               any
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_line
    assign gated[g] = req[g] & mask[g];
  end
  assign any = |gated;
endmodule

// File: rtl/intc_prio_enc.sv
module intc_prio_enc #(
  parameter int NUM_SRC = 8,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] lines,
  output logic [IDX_W-1:0]   idx,
  output logic               valid
);
  always_comb begin
    idx   = '0;
    valid = 1'b0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (lines[i]) begin
        idx   = IDX_W'(i);
        valid = 1'b1;
      end
    end
  end
endmodule

// File: rtl/intc_ctrl_regs.sv
module intc_ctrl_regs
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [1:0]         addr,
  input  logic [NUM_SRC-1:0] wdata,
  input  logic               ack_rise,
  input  logic               any_req,
  output logic [NUM_SRC-1:0] mask_q,
  output logic               ien_q,
  output logic               ist_q
);
  logic wr_mask, wr_en, wr_clr;
  assign wr_mask = we && (addr == RA_MASK);
  assign wr_en   = we && (addr == RA_ENABLE);
  assign wr_clr  = we && (addr == RA_STS_CLR);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      ien_q  <= 1'b0;
      ist_q  <= 1'b0;
    end else begin
      if (wr_mask) mask_q <= wdata;
      if (ack_rise)   ien_q <= 1'b0;
      else if (wr_en) ien_q <= wdata[0];
      ist_q <= any_req | (ist_q & ~wr_clr);
    end
  end
endmodule

// File: rtl/intc_vector.sv
module intc_vector #(
  parameter int          NUM_SRC  = 8,
  parameter int          VEC_W    = 16,
  parameter logic [15:0] VEC_BASE = 16'h0100,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inta,
  input  logic [IDX_W-1:0] idx,
  input  logic             valid,
  output logic             ack_rise,
  output logic [VEC_W-1:0] vec_q
);
  logic             inta_d;
  logic [VEC_W-1:0] vec_calc;

  assign ack_rise = inta & ~inta_d;
  assign vec_calc = VEC_W'(VEC_BASE) + (VEC_W'(idx) << 2);

  always_ff @(posedge clk) begin
    if (rst) begin
      inta_d <= 1'b0;
      vec_q  <= '0;
    end else begin
      inta_d <= inta;
      if (!inta)         vec_q <= '0;
      else if (ack_rise) vec_q <= valid ? vec_calc : '0;
    end
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import intc_pkg::*;
#(
  parameter int          NUM_SRC  = 8,
  parameter int          VEC_W    = 16,
  parameter logic [15:0] VEC_BASE = 16'h0100,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               reg_we,
  input  logic [1:0]         reg_addr,
  input  logic [NUM_SRC-1:0] reg_wdata,
  input  logic               inta_i,
  output logic               irq_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic               ien_o,
  output logic               ist_o,
  output logic [NUM_SRC-1:0] mask_o
);
  logic [NUM_SRC-1:0] gated;
  logic               any_req, enc_valid, ack_rise;
  logic [IDX_W-1:0]   enc_idx;

  intc_mask_gate #(.NUM_SRC(NUM_SRC)) u_gate (
    .req(req_i), .mask(mask_o), .gated(gated), .any(any_req)
  );

  intc_prio_enc #(.NUM_SRC(NUM_SRC)) u_enc (
    .lines(gated), .idx(enc_idx), .valid(enc_valid)
  );

  intc_ctrl_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .ack_rise(ack_rise), .any_req(any_req),
    .mask_q(mask_o), .ien_q(ien_o), .ist_q(ist_o)
  );

  intc_vector #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) u_vec (
    .clk(clk), .rst(rst), .inta(inta_i), .idx(enc_idx), .valid(enc_valid),
    .ack_rise(ack_rise), .vec_q(vec_o)
  );

  assign irq_o = ien_o & ist_o;

  // R1: the encoder's pick is always an active unmasked line
  assert_enc_pick_active_R1: assert property (@(posedge clk) disable iff (rst)
    enc_valid |-> gated[enc_idx]);

  // R2: no valid pick when every request is masked off
  assert_enc_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (gated == '0) |-> !enc_valid);

  // R3: an unmasked request sets the status flag on the next edge
  assert_ist_set_R3: assert property (@(posedge clk) disable iff (rst)
    (|(req_i & mask_o)) |=> ist_o);

  // R4: the enable flag moves only on an enable write or an acknowledge
  assert_ien_sw_only_R4: assert property (@(posedge clk) disable iff (rst)
    (!(reg_we && reg_addr == RA_ENABLE) && !ack_rise) |=> $stable(ien_o));

  // R6: the acknowledge edge clears the enable flag
  assert_ien_clr_ack_R6: assert property (@(posedge clk) disable iff (rst)
    ack_rise |=> !ien_o);

  // R7: the captured vector holds while acknowledge stays high
  assert_vec_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (inta_i && !ack_rise) |=> (inta_i ? $stable(vec_o) : 1'b1));

  // R8: the vector is 0 after acknowledge has been low
  assert_vec_zero_R8: assert property (@(posedge clk) disable iff (rst)
    !inta_i |=> (vec_o == '0));
endmodule

// File: tb/sim_prio_intc.sv
module sim_prio_intc;
  localparam int N = 8;
  localparam logic [15:0] BASE = 16'h0100;

  logic clk = 1'b0, rst = 1'b1;
  logic [N-1:0] req = '0, wdata = '0;
  logic we = 1'b0, inta = 1'b0;
  logic [1:0] addr = '0;
  logic irq, ien, ist;
  logic [15:0] vec;
  logic [N-1:0] mask;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  prio_intc #(.NUM_SRC(N), .VEC_W(16), .VEC_BASE(BASE)) u0 (
    .clk(clk), .rst(rst), .req_i(req), .reg_we(we), .reg_addr(addr),
    .reg_wdata(wdata), .inta_i(inta), .irq_o(irq), .vec_o(vec),
    .ien_o(ien), .ist_o(ist), .mask_o(mask)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    we = 1'b1; addr = a; wdata = d;
    step();
    we = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    step(); step();
    rst = 1'b0;
    chk("R10 irq", irq, 0); chk("R10 vec", vec, 0);
    chk("R10 ien", ien, 0); chk("R10 ist", ist, 0); chk("R10 mask", mask, 0);
  endtask

  task automatic t_masked_ignored();
    req = '1;
    step();
    chk("R2 ist stays 0 under full mask", ist, 0);
    req = '0;
    wr(2'd0, 8'hA5);
    chk("R9 mask load", mask, 8'hA5);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_enable();
    wr(2'd1, 8'h01);
    chk("R4 ien set by write", ien, 1);
    chk("R5 irq low with ist 0", irq, 0);
    wr(2'd3, 8'h00);
    chk("R4 spare write no effect", ien, 1);
  endtask

  task automatic t_priority_ack();
    wr(2'd0, 8'hFF);
    req = 8'b1010_0100;
    step();
    chk("R3 ist set", ist, 1);
    chk("R5 irq high", irq, 1);
    inta = 1'b1;
    step();
    chk("R1 R7 vector idx2", vec, BASE + 16'd8);
    chk("R6 ien cleared", ien, 0);
    chk("R5 irq low after ack", irq, 0);
    req = 8'h01;
    step();
    chk("R7 vector held", vec, BASE + 16'd8);
    inta = 1'b0;
    step();
    chk("R8 vector zero after ack", vec, 0);
  endtask

  task automatic t_mask_low();
    wr(2'd1, 8'h01);
    wr(2'd0, 8'hF0);
    req = 8'b1000_1111;
    step();
    inta = 1'b1;
    step();
    chk("R2 R1 masked low lines skipped", vec, BASE + 16'd28);
    inta = 1'b0;
    step();
  endtask

  task automatic t_clear();
    wr(2'd2, 8'h00);
    chk("R3 clear ignored while active", ist, 1);
    req = '0;
    step();
    wr(2'd2, 8'h00);
    chk("R3 clear works when idle", ist, 0);
  endtask

  task automatic t_ack_none();
    wr(2'd1, 8'h01);
    we = 1'b1; addr = 2'd1; wdata = 8'h01; inta = 1'b1;
    step();
    we = 1'b0;
    chk("R8 vector zero with no request", vec, 0);
    chk("R6 ack beats enable write", ien, 0);
    inta = 1'b0;
    step();
  endtask

  initial begin
    fork
      begin
        @(negedge clk);
        t_reset();
        t_masked_ignored();
        t_enable();
        t_priority_ack();
        t_mask_low();
        t_clear();
        t_ack_none();
        done = 1'b1;
      end
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          checks++; errors++;
          $display("FAIL watchdog actual=hung expected=done");
        end
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule